// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block interprets the multi-cycle write protocol of a parallel NOR flash that follows the common AMD-style command set. It sits between a simple bus port and the flash storage array. The bus port carries a request strobe, a write flag, a byte address and data, and returns registered read data. The storage port exposes a word address and a combinational read value, plus a write strobe. The block recognises the two unlock cycles and the program, autoselect, query-table and reset commands, and it tracks an unlock-bypass mode. It passes chip and sector erase requests to a separate erase controller, which reports completion with a pulse.

For every read, the block decides what comes back. The answer is array data, an identification code, a query-table byte or a status word, depending on the current mode. When the host keeps reading in a query mode without issuing commands, the block drops back to plain array reads after a fixed number of reads. Programming can only clear bits. The value written to storage is the existing word ANDed with the bus data.

Top module: `nor_cmd_seq`

## Requirements
- R1: After a synchronous active-high reset, the block is in array-read mode with unlock-bypass off. Reads return the storage word at the addressed location.
- R2: An unlock needs two write cycles: data 0xAA at the first unlock word address, then data 0x55 at the second. Any other write in either cycle returns to array mode, so a command written afterwards has no effect.
- R3: The word address is the bus byte address shifted right by log2(BUS_BYTES). Unlock address matching uses only bits [10:0] of the word address.
- R4: The cycle after an unlock is a command cycle, and it must hit the first unlock address. Its data is decoded as 0x80 erase setup, 0x90 autoselect, 0xA0 program or 0x20 bypass enable. A write to another address, or any other data, returns to array mode. The program data cycle writes (stored word AND bus data) to storage.
- R5: A program stays busy for PROG_CYCLES cycles. While busy, reads return a status word: bit 7 is the inverse of bit 7 of the programmed data, bit 6 flips on every status read, and all other bits are 0. After the busy time the block returns to array mode.
- R6: In autoselect mode, reads are decided by word offset bits [7:0]. Offset 0x00 returns ID0, 0x01 returns ID1 and 0x02 returns 0. Offsets 0x0E and 0x0F return ID2 and ID3, or array data when that code is 16'hFFFF. Every other offset returns array data.
- R7: A write of 0x98 from array mode, at a word address whose bits [7:0] are 0x55, enters query mode. A read at word offset N returns table byte N when N < CFI_BYTES, and 0 otherwise.
- R8: A write of 0x98 at offset 0x55 from autoselect enters a separate query mode. From there, 0xF0 returns to autoselect; from any other mode, 0xF0 returns to array mode.
- R9: After erase setup and a second unlock, there are two erase commands. 0x10 at the first unlock address gives a one-cycle erase_chip_go. 0x30 at any address gives a one-cycle erase_sector_go with erase_addr set to that word address.
- R10: Until erase_done, reads return status with bit 7 = 0, and bit 6 and bit 2 flip on every status read. All writes are ignored in this phase, 0xF0 included.
- R11: In autoselect and the two query modes, the first LAZY_READS reads with no intervening write are answered in that mode. The next read returns array data and leaves the block in array mode.
- R12: While bypass is on, one write from array mode is decoded as a command cycle at any address. A 0x00 write in autoselect turns bypass off.
- R13: bus_rdata and bus_rvalid are updated one cycle after a read request. bus_rvalid is high exactly in the cycle after each read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data; bits [7:0] carry commands |
| bus_rdata | output | DW | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| st_addr | output | WAW | Storage word address |
| st_rdata | input | DW | Storage word at st_addr (combinational) |
| st_we | output | 1 | Storage write strobe |
| st_wdata | output | DW | Storage write data |
| erase_chip_go | output | 1 | Chip erase start pulse |
| erase_sector_go | output | 1 | Sector erase start pulse |
| erase_addr | output | WAW | Word address of the sector erase |
| erase_done | input | 1 | Erase finished pulse from the erase controller |

## Verification
Two functions can fall in the same cycle. The first pair is the completion pulse from the erase controller and a status read. The bench drives erase_done in the cycle of the read request. It expects that read to return erase status, and the following read to return array data. The second pair is a 0xF0 write and the erase phase: the write must leave status reads running. The lazy fallback is also driven right up to its boundary, and the read just past the count must be answered as array data.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY, ST_UNLK1, ST_UNLK2, ST_PROG_DATA, ST_PROG_BUSY,
    ST_AUTOSEL, ST_QUERY, ST_AUTO_QUERY,
    ST_ERS_SETUP, ST_ERS_U1, ST_ERS_U2, ST_ERASING
  } seq_state_t;

  typedef enum logic [2:0] {
    RD_ARRAY, RD_IDENT, RD_QUERY, RD_PROG_STAT, RD_ERASE_STAT
  } rd_src_t;

  localparam logic [7:0] CMD_KEY1     = 8'hAA;
  localparam logic [7:0] CMD_KEY2     = 8'h55;
  localparam logic [7:0] CMD_ERS_SET  = 8'h80;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_CHIP_ERS = 8'h10;
  localparam logic [7:0] CMD_SECT_ERS = 8'h30;
  localparam logic [7:0] CMD_BYP_EXIT = 8'h00;

  function automatic logic is_query_mode(seq_state_t s);
    return (s == ST_AUTOSEL) || (s == ST_QUERY) || (s == ST_AUTO_QUERY);
  endfunction

  function automatic rd_src_t read_source(seq_state_t s);
    case (s)
      ST_AUTOSEL:    return RD_IDENT;
      ST_QUERY:      return RD_QUERY;
      ST_AUTO_QUERY: return RD_QUERY;
      ST_PROG_BUSY:  return RD_PROG_STAT;
      ST_ERASING:    return RD_ERASE_STAT;
      default:       return RD_ARRAY;
    endcase
  endfunction

  function automatic seq_state_t decode_command(logic [7:0] c);
    case (c)
      CMD_ERS_SET: return ST_ERS_SETUP;
      CMD_IDENT:   return ST_AUTOSEL;
      CMD_PROGRAM: return ST_PROG_DATA;
      default:     return ST_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nor_addr_decode.sv
module nor_addr_decode #(
  parameter int AW = 16,
  parameter int BUS_BYTES = 2,
  parameter logic [10:0] UNLOCK_A = 11'h555,
  parameter logic [10:0] UNLOCK_B = 11'h2AA,
  localparam int SHIFT = $clog2(BUS_BYTES),
  localparam int WAW = AW - SHIFT
) (
  input  logic [AW-1:0]  bus_addr,
  output logic [WAW-1:0] word_addr,
  output logic           hit_a,
  output logic           hit_b,
  output logic           hit_query
);

  generate
    if (SHIFT == 0) begin : g_byte
      assign word_addr = bus_addr;
    end else begin : g_wide
      assign word_addr = bus_addr[AW-1:SHIFT];
    end
  endgenerate

  assign hit_a     = (word_addr[10:0] == UNLOCK_A);
  assign hit_b     = (word_addr[10:0] == UNLOCK_B);
  assign hit_query = (word_addr[7:0] == 8'h55);

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int PROG_CYCLES = 8,
  parameter int LAZY_READS = 42,
  localparam int PCW = $clog2(PROG_CYCLES + 1),
  localparam int LCW = $clog2(LAZY_READS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_go,
  input  logic       rd_go,
  input  logic [7:0] cmd,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       hit_query,
  input  logic       erase_done,
  output seq_state_t state,
  output logic       lazy_fire,
  output logic       prog_start,
  output logic       chip_go,
  output logic       sector_go
);

  seq_state_t nxt;
  logic bypass, nbypass;
  logic [PCW-1:0] prog_cnt;
  logic [LCW-1:0] lazy_cnt;
  logic reset_ok;

  assign lazy_fire = rd_go && is_query_mode(state) && (lazy_cnt == LCW'(LAZY_READS));
  assign reset_ok  = (state != ST_PROG_DATA) && (state != ST_PROG_BUSY) && (state != ST_ERASING);

  always_comb begin
    nxt        = state;
    nbypass    = bypass;
    prog_start = 1'b0;
    chip_go    = 1'b0;
    sector_go  = 1'b0;
    if (state == ST_ERASING) begin
      if (erase_done) nxt = ST_ARRAY;
    end else if (state == ST_PROG_BUSY) begin
      if (prog_cnt == '0) nxt = ST_ARRAY;
    end else if (wr_go) begin
      if (cmd == CMD_RESET && reset_ok) begin
        nxt = (state == ST_AUTO_QUERY) ? ST_AUTOSEL : ST_ARRAY;
      end else begin
        case (state)
          ST_ARRAY: begin
            if (hit_query && cmd == CMD_QUERY) nxt = ST_QUERY;
            else if (bypass) nxt = decode_command(cmd);
            else if (hit_a && cmd == CMD_KEY1) nxt = ST_UNLK1;
          end
          ST_UNLK1: nxt = (hit_b && cmd == CMD_KEY2) ? ST_UNLK2 : ST_ARRAY;
          ST_UNLK2: begin
            if (!hit_a) nxt = ST_ARRAY;
            else begin
              nxt = decode_command(cmd);
              if (cmd == CMD_BYPASS) nbypass = 1'b1;
            end
          end
          ST_PROG_DATA: begin
            prog_start = 1'b1;
            nxt = ST_PROG_BUSY;
          end
          ST_AUTOSEL: begin
            if (bypass && cmd == CMD_BYP_EXIT) begin
              nbypass = 1'b0;
              nxt = ST_ARRAY;
            end else if (hit_query && cmd == CMD_QUERY) nxt = ST_AUTO_QUERY;
            else nxt = ST_ARRAY;
          end
          ST_ERS_SETUP: nxt = (hit_a && cmd == CMD_KEY1) ? ST_ERS_U1 : ST_ARRAY;
          ST_ERS_U1:    nxt = (hit_b && cmd == CMD_KEY2) ? ST_ERS_U2 : ST_ARRAY;
          ST_ERS_U2: begin
            if (cmd == CMD_CHIP_ERS && hit_a) begin
              chip_go = 1'b1;
              nxt = ST_ERASING;
            end else if (cmd == CMD_SECT_ERS) begin
              sector_go = 1'b1;
              nxt = ST_ERASING;
            end else nxt = ST_ARRAY;
          end
          default: nxt = ST_ARRAY;
        endcase
      end
    end else if (lazy_fire) begin
      nxt = ST_ARRAY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_ARRAY;
      bypass   <= 1'b0;
      prog_cnt <= '0;
      lazy_cnt <= '0;
    end else begin
      state  <= nxt;
      bypass <= nbypass;
      if (prog_start) prog_cnt <= PCW'(PROG_CYCLES - 1);
      else if (state == ST_PROG_BUSY && prog_cnt != '0) prog_cnt <= prog_cnt - PCW'(1);
      if (wr_go) lazy_cnt <= '0;
      else if (rd_go && is_query_mode(state)) lazy_cnt <= lazy_fire ? '0 : lazy_cnt + LCW'(1);
    end
  end

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int WAW = 15,
  parameter logic [15:0] ID0 = 16'h00C2,
  parameter logic [15:0] ID1 = 16'h4A5D,
  parameter logic [15:0] ID2 = 16'h1B07,
  parameter logic [15:0] ID3 = 16'hFFFF,
  parameter int CFI_BYTES = 32,
  parameter logic [CFI_BYTES*8-1:0] CFI_TABLE = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_go,
  input  rd_src_t        src,
  input  logic [WAW-1:0] word_addr,
  input  logic [DW-1:0]  st_rdata,
  input  logic           prog_start,
  input  logic           prog_bit7,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid
);

  logic tog6, tog2, d7_inv;
  logic [7:0] off;
  logic [DW-1:0] ident_val, query_val, prog_stat, ers_stat, sel_val;

  assign off = word_addr[7:0];

  always_comb begin
    case (off)
      8'h00:   ident_val = DW'(ID0);
      8'h01:   ident_val = DW'(ID1);
      8'h02:   ident_val = '0;
      8'h0E:   ident_val = (ID2 == 16'hFFFF) ? st_rdata : DW'(ID2);
      8'h0F:   ident_val = (ID3 == 16'hFFFF) ? st_rdata : DW'(ID3);
      default: ident_val = st_rdata;
    endcase
  end

  always_comb begin
    query_val = '0;
    if (int'(off) < CFI_BYTES) query_val = DW'(CFI_TABLE[int'(off)*8 +: 8]);
  end

  assign prog_stat = DW'({d7_inv, tog6, 6'b0});
  assign ers_stat  = DW'({1'b0, tog6, 3'b0, tog2, 2'b0});

  always_comb begin
    case (src)
      RD_IDENT:      sel_val = ident_val;
      RD_QUERY:      sel_val = query_val;
      RD_PROG_STAT:  sel_val = prog_stat;
      RD_ERASE_STAT: sel_val = ers_stat;
      default:       sel_val = st_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tog6       <= 1'b0;
      tog2       <= 1'b0;
      d7_inv     <= 1'b0;
    end else begin
      bus_rvalid <= rd_go;
      if (prog_start) d7_inv <= ~prog_bit7;
      if (rd_go) begin
        bus_rdata <= sel_val;
        if (src == RD_PROG_STAT || src == RD_ERASE_STAT) tog6 <= ~tog6;
        if (src == RD_ERASE_STAT) tog2 <= ~tog2;
      end
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int BUS_BYTES = 2,
  parameter logic [10:0] UNLOCK_A = 11'h555,
  parameter logic [10:0] UNLOCK_B = 11'h2AA,
  parameter logic [15:0] ID0 = 16'h00C2,
  parameter logic [15:0] ID1 = 16'h4A5D,
  parameter logic [15:0] ID2 = 16'h1B07,
  parameter logic [15:0] ID3 = 16'hFFFF,
  parameter int CFI_BYTES = 32,
  parameter logic [CFI_BYTES*8-1:0] CFI_TABLE = {96'h0, 8'h02, 8'h59, 8'h52, 8'h51, 128'h0},
  parameter int PROG_CYCLES = 8,
  parameter int LAZY_READS = 42,
  localparam int DW = 8 * BUS_BYTES,
  localparam int WAW = AW - $clog2(BUS_BYTES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  output logic [WAW-1:0] st_addr,
  input  logic [DW-1:0]  st_rdata,
  output logic           st_we,
  output logic [DW-1:0]  st_wdata,
  output logic           erase_chip_go,
  output logic           erase_sector_go,
  output logic [WAW-1:0] erase_addr,
  input  logic           erase_done
);

  logic wr_go, rd_go, hit_a, hit_b, hit_query;
  logic lazy_fire, prog_start, chip_go, sector_go;
  logic [WAW-1:0] word_addr;
  seq_state_t state;
  rd_src_t src;

  assign wr_go = bus_req && bus_we;
  assign rd_go = bus_req && !bus_we;

  nor_addr_decode #(
    .AW(AW), .BUS_BYTES(BUS_BYTES), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_dec (
    .bus_addr(bus_addr), .word_addr(word_addr),
    .hit_a(hit_a), .hit_b(hit_b), .hit_query(hit_query)
  );

  nor_cmd_fsm #(.PROG_CYCLES(PROG_CYCLES), .LAZY_READS(LAZY_READS)) u_fsm (
    .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .cmd(bus_wdata[7:0]),
    .hit_a(hit_a), .hit_b(hit_b), .hit_query(hit_query), .erase_done(erase_done),
    .state(state), .lazy_fire(lazy_fire), .prog_start(prog_start),
    .chip_go(chip_go), .sector_go(sector_go)
  );

  assign src = lazy_fire ? RD_ARRAY : read_source(state);

  nor_read_mux #(
    .DW(DW), .WAW(WAW), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3),
    .CFI_BYTES(CFI_BYTES), .CFI_TABLE(CFI_TABLE)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_go(rd_go), .src(src), .word_addr(word_addr),
    .st_rdata(st_rdata), .prog_start(prog_start), .prog_bit7(bus_wdata[7]),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  assign st_addr  = word_addr;
  assign st_we    = prog_start;
  assign st_wdata = st_rdata & bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      erase_chip_go   <= 1'b0;
      erase_sector_go <= 1'b0;
      erase_addr      <= '0;
    end else begin
      erase_chip_go   <= chip_go;
      erase_sector_go <= sector_go;
      if (chip_go || sector_go) erase_addr <= word_addr;
    end
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_rvalid,
  input logic          st_we,
  input logic [DW-1:0] st_wdata,
  input logic [DW-1:0] st_rdata,
  input logic          erase_chip_go,
  input logic          erase_sector_go
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bus_rvalid && !erase_chip_go && !erase_sector_go));

  // R4
  and_only_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> ((st_wdata & ~st_rdata) == '0));

  // R4
  prog_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (bus_req && bus_we));

  // R9
  erase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_chip_go, erase_sector_go}));

  // R9
  erase_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (erase_chip_go || erase_sector_go) |-> $past(bus_req && bus_we));

  // R13
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  // R13
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !bus_rvalid);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_rvalid(bus_rvalid),
  .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata),
  .erase_chip_go(erase_chip_go), .erase_sector_go(erase_sector_go)
);

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata, st_rdata, st_wdata;
  logic        bus_rvalid, st_we, erase_chip_go, erase_sector_go;
  logic [14:0] st_addr, erase_addr;
  logic        erase_done = 1'b0;

  int vecs = 0, errs = 0;
  bit done = 0;
  logic [15:0] mem [256];

  always #2.5 clk = ~clk;

  nor_cmd_seq #(
    .AW(16), .BUS_BYTES(2), .UNLOCK_A(11'h555), .UNLOCK_B(11'h2AA),
    .ID0(16'h00C2), .ID1(16'h4A5D), .ID2(16'h1B07), .ID3(16'hFFFF),
    .CFI_BYTES(32), .CFI_TABLE({96'h0, 8'h02, 8'h59, 8'h52, 8'h51, 128'h0}),
    .PROG_CYCLES(8), .LAZY_READS(42)
  ) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .st_addr(st_addr), .st_rdata(st_rdata), .st_we(st_we), .st_wdata(st_wdata),
    .erase_chip_go(erase_chip_go), .erase_sector_go(erase_sector_go),
    .erase_addr(erase_addr), .erase_done(erase_done)
  );

  function automatic logic [15:0] pat(int i);
    return 16'(i * 40503) ^ 16'h3C96;
  endfunction

  assign st_rdata = mem[st_addr[7:0]];
  always @(posedge clk) if (st_we) mem[st_addr[7:0]] <= st_wdata;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [14:0] w, logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = {w, 1'b0}; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [14:0] w, output logic [15:0] d, output logic v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = {w, 1'b0};
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic unlk();
    wr(15'h555, 16'h00AA);
    wr(15'h2AA, 16'h0055);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic v;
    rd(15'd5, d, v);
    chk("R1 array read after reset", d, pat(5));
    chk("R13 rvalid after read", v, 1);
    idle(1);
    chk("R13 rvalid low when idle", bus_rvalid, 0);
  endtask

  task automatic t_unlock();
    logic [15:0] d; logic v;
    wr(15'h555, 16'h00AA); wr(15'h2AA, 16'h0054); wr(15'h555, 16'h0090);
    rd(15'd0, d, v);
    chk("R2 bad second key ignored", d, pat(0));
    unlk(); wr(15'h100, 16'h0090);
    rd(15'd0, d, v);
    chk("R4 command off unlock address", d, pat(0));
    unlk(); wr(15'h555, 16'h0077);
    rd(15'd1, d, v);
    chk("R4 unknown command", d, pat(1));
  endtask

  task automatic t_autosel();
    logic [15:0] d; logic v;
    wr(15'h1555, 16'h00AA); wr(15'h12AA, 16'h0055); wr(15'h3555, 16'h0090);
    rd(15'd0, d, v);   chk("R3 R6 ident word 0", d, 16'h00C2);
    rd(15'd1, d, v);   chk("R6 ident word 1", d, 16'h4A5D);
    rd(15'd2, d, v);   chk("R6 protect word", d, 16'h0000);
    rd(15'h0E, d, v);  chk("R6 ident word 0x0E", d, 16'h1B07);
    rd(15'h0F, d, v);  chk("R6 all-ones code gives array", d, pat(15));
    rd(15'd7, d, v);   chk("R6 other word gives array", d, pat(7));
    wr(15'd0, 16'h00F0);
    rd(15'd0, d, v);   chk("R8 reset from autoselect", d, pat(0));
  endtask

  task automatic t_program();
    logic [15:0] s1, s2, d; logic v;
    unlk(); wr(15'h555, 16'h00A0); wr(15'd10, 16'h0F0F);
    rd(15'd10, s1, v); rd(15'd10, s2, v);
    chk("R5 status bit7 inverse of data", s1 & 16'hFFBF, 16'h0080);
    chk("R5 status bit6 toggles", (s1 ^ s2) & 16'h0040, 16'h0040);
    idle(12);
    rd(15'd10, d, v);
    chk("R4 R5 AND programming then array", d, pat(10) & 16'h0F0F);
    unlk(); wr(15'h555, 16'h00A0); wr(15'd12, 16'hFF80);
    rd(15'd12, s1, v);
    chk("R5 status bit7 clear for data bit7 set", s1 & 16'hFFBF, 16'h0000);
    idle(12);
    rd(15'd12, d, v);
    chk("R4 second program", d, pat(12) & 16'hFF80);
  endtask

  task automatic t_query();
    logic [15:0] d; logic v;
    wr(15'h0155, 16'h0098);
    rd(15'h10, d, v);  chk("R7 table byte 0x10", d, 16'h0051);
    rd(15'h13, d, v);  chk("R7 table byte 0x13", d, 16'h0002);
    rd(15'h20, d, v);  chk("R7 beyond table", d, 16'h0000);
    wr(15'd0, 16'h00F0);
    rd(15'h10, d, v);  chk("R8 reset from query", d, pat(16));
    unlk(); wr(15'h555, 16'h0090); wr(15'h55, 16'h0098);
    rd(15'h11, d, v);  chk("R8 autoselect query table", d, 16'h0052);
    wr(15'd0, 16'h00F0);
    rd(15'd0, d, v);   chk("R8 reset returns to autoselect", d, 16'h00C2);
    wr(15'd0, 16'h00F0);
    rd(15'd0, d, v);   chk("R8 second reset to array", d, pat(0));
  endtask

  task automatic t_erase();
    logic [15:0] s1, s2, s3, d; logic v;
    unlk(); wr(15'h555, 16'h0080); unlk(); wr(15'h555, 16'h0010);
    chk("R9 chip erase pulse", erase_chip_go, 1);
    chk("R9 no sector pulse", erase_sector_go, 0);
    rd(15'd3, s1, v); rd(15'd3, s2, v);
    chk("R10 erase status bits", s1 & 16'hFFBB, 16'h0000);
    chk("R10 bit6 and bit2 toggle", (s1 ^ s2) & 16'h0044, 16'h0044);
    wr(15'd0, 16'h00F0);
    rd(15'd3, s3, v);
    chk("R10 reset ignored during erase", (s3 ^ s2) & 16'hFFFF, 16'h0044);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = {15'd3, 1'b0}; erase_done = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; erase_done = 1'b0;
    chk("R10 read with done still status", bus_rdata & 16'hFFBB, 16'h0000);
    rd(15'd3, d, v);
    chk("R10 array after done", d, pat(3));
    unlk(); wr(15'h555, 16'h0080); unlk(); wr(15'h40, 16'h0030);
    chk("R9 sector erase pulse", erase_sector_go, 1);
    chk("R9 sector erase address", erase_addr, 15'h40);
    chk("R9 no chip pulse", erase_chip_go, 0);
    idle(1);
    chk("R9 pulse one cycle", erase_sector_go, 0);
    @(negedge clk); erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    rd(15'h40, d, v);
    chk("R10 array after sector done", d, pat(64));
  endtask

  task automatic t_lazy();
    logic [15:0] d; logic v;
    wr(15'h55, 16'h0098);
    for (int i = 0; i < 42; i++) begin
      rd(15'h10, d, v);
      chk("R11 query read within count", d, 16'h0051);
    end
    rd(15'h10, d, v); chk("R11 fallback read gives array", d, pat(16));
    rd(15'h10, d, v); chk("R11 stays in array", d, pat(16));
  endtask

  task automatic t_bypass();
    logic [15:0] d; logic v;
    unlk(); wr(15'h555, 16'h0020);
    wr(15'h300, 16'h00A0); wr(15'd20, 16'h3C3C);
    idle(12);
    rd(15'd20, d, v); chk("R12 bypass program", d, pat(20) & 16'h3C3C);
    wr(15'h123, 16'h0090);
    rd(15'd1, d, v);  chk("R12 bypass autoselect", d, 16'h4A5D);
    wr(15'd0, 16'h0000);
    wr(15'h300, 16'h00A0); wr(15'd21, 16'h0000);
    idle(12);
    rd(15'd21, d, v); chk("R12 bypass exited", d, pat(21));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unlock();
    t_autosel();
    t_program();
    t_query();
    t_erase();
    t_lazy();
    t_bypass();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule